// File: doc/BRIEF.md
# Pre-Execution Result Buffer

This block keeps results that were worked out early for writes that have not yet reached the memory controller. Software-side hints arrive as object-sized requests. Each request carries an identifier, a thread number, a transaction number, a start byte address, a byte size and an optional data word. A splitter turns every request that names an address into one entry per 64-byte line the object touches. Each entry lands in an eight-slot associative store. An entry whose data is already known holds a placeholder result computed from that data and its line address. An entry created from an address alone waits for a data-only request with the same identifier, thread and transaction, which completes it.

When a real write arrives, the store is searched by line address. An entry that is complete and whose saved data equals the write data supplies its result and is released. Every other case invalidates any entry for that line and raises a fallback flag, so the write takes the ordinary path. A wrong or redundant hint therefore only costs hits. Entries that are never claimed expire after a programmable number of cycles. When the store is full, the oldest entry is overwritten.

Top module: `prexec_result_buf`

## Requirements
- R1: After reset, `pre_ready` is 1, `rsp_valid`, `rsp_hit` and `rsp_fallback` are 0, and the store is empty, so the first write misses.
- R2: A request whose kind names an address, with size S > 0 at byte address A, creates entries for lines floor(A/64) through floor((A+S-1)/64). One line is created per cycle, and `pre_ready` is 0 for exactly that many cycles after the accepting edge. A size of 0 creates nothing.
- R3: `pre_kind` bit 0 means an address is present and bit 1 means data is present: 2'b01 address only, 2'b10 data only, 2'b11 both. Kind 2'b00 is accepted and has no effect.
- R4: An entry made with both address and data hits for a write to the same line with equal data. The result is (data XOR (byte address >> 6)) + 32'h3C6EF372, and the same data word applies to every line of the object.
- R5: Each write presented for one cycle yields exactly one response. `rsp_valid` is high in the second cycle after the write cycle and low in the cycle between.
- R6: A response without a hit has `rsp_fallback` = 1, `rsp_hit` = 0 and `rsp_result` = 0. A hit has `rsp_fallback` = 0.
- R7: A write to a stored line with different data misses and invalidates that entry, so a repeat with the correct data also misses.
- R8: A hit consumes its entry, so an identical second write misses.
- R9: An address-only entry is data-pending. A write that claims it misses and removes it. A data-only request fills it only if identifier, thread and transaction all match, after which a write with that data hits.
- R10: An unclaimed entry still hits a few hundred cycles after allocation, but is gone once `TMO_LIMIT` (default 2000) cycles have passed.
- R11: When all eight entries are in use, a new line replaces the entry allocated earliest. The other seven still hit.
- R12: Allocating a line that is already stored replaces that entry, so only the newest data and result for the line remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pre_valid | input | 1 | Pre-execution request present |
| pre_ready | output | 1 | Request accepted this cycle when high with `pre_valid` |
| pre_kind | input | 2 | Bit 0 address present, bit 1 data present |
| pre_id | input | 4 | Request identifier |
| pre_thread | input | 3 | Thread number |
| pre_txn | input | 8 | Transaction number |
| pre_addr | input | 32 | Object start byte address |
| pre_size | input | 16 | Object size in bytes |
| pre_data | input | 32 | Data word the result is computed from |
| wr_valid | input | 1 | Real write present |
| wr_addr | input | 32 | Write byte address |
| wr_data | input | 32 | Write data word |
| rsp_valid | output | 1 | Lookup response |
| rsp_hit | output | 1 | Stored result used |
| rsp_result | output | 32 | Stored result, 0 on miss |
| rsp_fallback | output | 1 | Write must take the normal path |

## Verification
The directed scenarios target the points where a weak design would silently return a wrong result. The first is a data mismatch: without invalidation, the entry would be kept and hit later. The second is a pending entry that a write claims before its data arrives: the write would hit on stale data. The third is a data-only request with a wrong thread or transaction: if it filled the entry, the correct fill would no longer apply. The scenarios also cover an object that straddles line boundaries (an off-by-one in the line count), re-hinting the same line (two copies, or the old result returned), expiry, and replacement in a full store (the newest rather than the oldest entry evicted).

// File: rtl/prb_pkg.sv
package prb_pkg;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] MIX_K = 32'h3C6E_F372;

  // placeholder for the real back-end computation
  function automatic logic [DATA_W-1:0] prb_result(input logic [DATA_W-1:0] d,
                                                   input logic [DATA_W-1:0] line);
    return (d ^ line) + MIX_K;
  endfunction
endpackage

// File: rtl/prb_splitter.sv
module prb_splitter #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int SZ_W   = 16,
  parameter int ID_W   = 4,
  parameter int TH_W   = 3,
  parameter int TX_W   = 8,
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_take,
  input  logic [1:0]               req_kind,
  input  logic [ID_W-1:0]          req_id,
  input  logic [TH_W-1:0]          req_thread,
  input  logic [TX_W-1:0]          req_txn,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [SZ_W-1:0]          req_size,
  input  logic [prb_pkg::DATA_W-1:0] req_data,
  output logic                     busy,
  output logic                     alloc_valid,
  output logic [LINE_W-1:0]        alloc_line,
  output logic                     alloc_pending,
  output logic [ID_W-1:0]          alloc_id,
  output logic [TH_W-1:0]          alloc_thread,
  output logic [TX_W-1:0]          alloc_txn,
  output logic [prb_pkg::DATA_W-1:0] alloc_data
);
  logic              busy_q, busy_d;
  logic [LINE_W-1:0] cur_q, cur_d, rem_q, rem_d;
  logic              pend_q, pend_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic [TH_W-1:0]   th_q, th_d;
  logic [TX_W-1:0]   tx_q, tx_d;
  logic [prb_pkg::DATA_W-1:0] dat_q, dat_d;
  logic [ADDR_W-1:0] end_addr;
  logic              start;
  logic              unused_low;

  assign end_addr   = req_addr + ADDR_W'(req_size) - ADDR_W'(1);
  assign unused_low = ^end_addr[OFF_W-1:0];
  assign start      = req_take && req_kind[0] && (req_size != '0);

  always_comb begin
    busy_d = busy_q;
    cur_d  = cur_q;
    rem_d  = rem_q;
    pend_d = pend_q;
    id_d   = id_q;
    th_d   = th_q;
    tx_d   = tx_q;
    dat_d  = dat_q;
    if (busy_q) begin
      cur_d = cur_q + LINE_W'(1);
      rem_d = rem_q - LINE_W'(1);
      if (rem_q == LINE_W'(1)) busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      cur_d  = req_addr[ADDR_W-1:OFF_W];
      rem_d  = end_addr[ADDR_W-1:OFF_W] - req_addr[ADDR_W-1:OFF_W] + LINE_W'(1);
      pend_d = ~req_kind[1];
      id_d   = req_id;
      th_d   = req_thread;
      tx_d   = req_txn;
      dat_d  = req_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      rem_q  <= '0;
      pend_q <= 1'b0;
      id_q   <= '0;
      th_q   <= '0;
      tx_q   <= '0;
      dat_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cur_q  <= cur_d;
      rem_q  <= rem_d;
      pend_q <= pend_d;
      id_q   <= id_d;
      th_q   <= th_d;
      tx_q   <= tx_d;
      dat_q  <= dat_d;
    end
  end

  assign busy          = busy_q;
  assign alloc_valid   = busy_q;
  assign alloc_line    = cur_q;
  assign alloc_pending = pend_q;
  assign alloc_id      = id_q;
  assign alloc_thread  = th_q;
  assign alloc_txn     = tx_q;
  assign alloc_data    = dat_q;
endmodule

// File: rtl/prb_store.sv
module prb_store #(
  parameter int ENTRIES   = 8,
  parameter int LINE_W    = 26,
  parameter int ID_W      = 4,
  parameter int TH_W      = 3,
  parameter int TX_W      = 8,
  parameter int TMO_W     = 16,
  parameter logic [TMO_W-1:0] TMO_LIMIT = 16'd2000,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int DW       = prb_pkg::DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [LINE_W-1:0]  alloc_line,
  input  logic               alloc_pending,
  input  logic [ID_W-1:0]    alloc_id,
  input  logic [TH_W-1:0]    alloc_thread,
  input  logic [TX_W-1:0]    alloc_txn,
  input  logic [DW-1:0]      alloc_data,
  input  logic               fill_valid,
  input  logic [ID_W-1:0]    fill_id,
  input  logic [TH_W-1:0]    fill_thread,
  input  logic [TX_W-1:0]    fill_txn,
  input  logic [DW-1:0]      fill_data,
  input  logic               lk_valid,
  input  logic [LINE_W-1:0]  lk_line,
  input  logic [DW-1:0]      lk_data,
  output logic [ENTRIES-1:0] lk_match,
  output logic               lk_hit,
  output logic [DW-1:0]      lk_result
);
  logic [ENTRIES-1:0] val_q, val_d, pnd_q, pnd_d;
  logic [LINE_W-1:0]  lin_q [ENTRIES];
  logic [LINE_W-1:0]  lin_d [ENTRIES];
  logic [ID_W-1:0]    id_q  [ENTRIES];
  logic [ID_W-1:0]    id_d  [ENTRIES];
  logic [TH_W-1:0]    th_q  [ENTRIES];
  logic [TH_W-1:0]    th_d  [ENTRIES];
  logic [TX_W-1:0]    tx_q  [ENTRIES];
  logic [TX_W-1:0]    tx_d  [ENTRIES];
  logic [DW-1:0]      dat_q [ENTRIES];
  logic [DW-1:0]      dat_d [ENTRIES];
  logic [DW-1:0]      res_q [ENTRIES];
  logic [DW-1:0]      res_d [ENTRIES];
  logic [TMO_W-1:0]   tmr_q [ENTRIES];
  logic [TMO_W-1:0]   tmr_d [ENTRIES];

  logic [IDX_W-1:0] victim, dup_idx, free_idx, old_idx;
  logic             dup_found, free_found;
  logic [TMO_W-1:0] old_t;
  logic [ENTRIES-1:0] hit_vec;

  // replacement choice: same line, then free slot, then oldest timer
  always_comb begin
    dup_found  = 1'b0;
    free_found = 1'b0;
    dup_idx    = '0;
    free_idx   = '0;
    old_idx    = '0;
    old_t      = tmr_q[0];
    for (int i = 0; i < ENTRIES; i++) begin
      if (val_q[i] && lin_q[i] == alloc_line && !dup_found) begin
        dup_found = 1'b1;
        dup_idx   = IDX_W'(i);
      end
      if (!val_q[i] && !free_found) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
      if (tmr_q[i] > old_t) begin
        old_t   = tmr_q[i];
        old_idx = IDX_W'(i);
      end
    end
    victim = dup_found ? dup_idx : (free_found ? free_idx : old_idx);
  end

  // lookup by line
  always_comb begin
    lk_result = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_match[i] = val_q[i] && (lin_q[i] == lk_line);
      hit_vec[i]  = lk_match[i] && !pnd_q[i] && (dat_q[i] == lk_data);
      if (hit_vec[i]) lk_result = lk_result | res_q[i];
    end
    lk_hit = lk_valid && (|hit_vec);
    if (!lk_valid) lk_result = '0;
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      val_d[i] = val_q[i];
      pnd_d[i] = pnd_q[i];
      lin_d[i] = lin_q[i];
      id_d[i]  = id_q[i];
      th_d[i]  = th_q[i];
      tx_d[i]  = tx_q[i];
      dat_d[i] = dat_q[i];
      res_d[i] = res_q[i];
      tmr_d[i] = tmr_q[i];
      if (val_q[i]) begin
        if (tmr_q[i] == TMO_LIMIT) val_d[i] = 1'b0;
        else tmr_d[i] = tmr_q[i] + TMO_W'(1);
      end
      if (lk_valid && lk_match[i]) val_d[i] = 1'b0;
      if (fill_valid && val_q[i] && pnd_q[i] && id_q[i] == fill_id &&
          th_q[i] == fill_thread && tx_q[i] == fill_txn) begin
        pnd_d[i] = 1'b0;
        dat_d[i] = fill_data;
        res_d[i] = prb_pkg::prb_result(fill_data, DW'(lin_q[i]));
      end
      if (alloc_valid && victim == IDX_W'(i)) begin
        val_d[i] = 1'b1;
        pnd_d[i] = alloc_pending;
        lin_d[i] = alloc_line;
        id_d[i]  = alloc_id;
        th_d[i]  = alloc_thread;
        tx_d[i]  = alloc_txn;
        dat_d[i] = alloc_data;
        res_d[i] = prb_pkg::prb_result(alloc_data, DW'(alloc_line));
        tmr_d[i] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      pnd_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        lin_q[i] <= '0;
        id_q[i]  <= '0;
        th_q[i]  <= '0;
        tx_q[i]  <= '0;
        dat_q[i] <= '0;
        res_q[i] <= '0;
        tmr_q[i] <= '0;
      end
    end else begin
      val_q <= val_d;
      pnd_q <= pnd_d;
      for (int i = 0; i < ENTRIES; i++) begin
        lin_q[i] <= lin_d[i];
        id_q[i]  <= id_d[i];
        th_q[i]  <= th_d[i];
        tx_q[i]  <= tx_d[i];
        dat_q[i] <= dat_d[i];
        res_q[i] <= res_d[i];
        tmr_q[i] <= tmr_d[i];
      end
    end
  end
endmodule

// File: rtl/prexec_result_buf.sv
module prexec_result_buf #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int ENTRIES    = 8,
  parameter int SZ_W       = 16,
  parameter int ID_W       = 4,
  parameter int TH_W       = 3,
  parameter int TX_W       = 8,
  parameter int TMO_W      = 16,
  parameter logic [TMO_W-1:0] TMO_LIMIT = 16'd2000,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W,
  localparam int DW        = prb_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_valid,
  output logic              pre_ready,
  input  logic [1:0]        pre_kind,
  input  logic [ID_W-1:0]   pre_id,
  input  logic [TH_W-1:0]   pre_thread,
  input  logic [TX_W-1:0]   pre_txn,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [SZ_W-1:0]   pre_size,
  input  logic [DW-1:0]     pre_data,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DW-1:0]     rsp_result,
  output logic              rsp_fallback
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic              busy, take, fill_valid;
  logic              a_valid, a_pend;
  logic [LINE_W-1:0] a_line;
  logic [ID_W-1:0]   a_id;
  logic [TH_W-1:0]   a_th;
  logic [TX_W-1:0]   a_tx;
  logic [DW-1:0]     a_data;
  logic [ENTRIES-1:0] lk_match;
  logic              lk_hit;
  logic [DW-1:0]     lk_result;
  logic              unused_wr_low;

  assign pre_ready     = ~busy;
  assign take          = pre_valid && pre_ready;
  assign fill_valid    = take && (pre_kind == 2'b10);
  assign unused_wr_low = ^wr_addr[OFF_W-1:0];

  prb_splitter #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SZ_W(SZ_W),
    .ID_W(ID_W), .TH_W(TH_W), .TX_W(TX_W)
  ) u_split (
    .clk(clk), .rst_n(rst_sync_n),
    .req_take(take), .req_kind(pre_kind), .req_id(pre_id),
    .req_thread(pre_thread), .req_txn(pre_txn), .req_addr(pre_addr),
    .req_size(pre_size), .req_data(pre_data),
    .busy(busy), .alloc_valid(a_valid), .alloc_line(a_line),
    .alloc_pending(a_pend), .alloc_id(a_id), .alloc_thread(a_th),
    .alloc_txn(a_tx), .alloc_data(a_data)
  );

  prb_store #(
    .ENTRIES(ENTRIES), .LINE_W(LINE_W), .ID_W(ID_W), .TH_W(TH_W),
    .TX_W(TX_W), .TMO_W(TMO_W), .TMO_LIMIT(TMO_LIMIT)
  ) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .alloc_valid(a_valid), .alloc_line(a_line), .alloc_pending(a_pend),
    .alloc_id(a_id), .alloc_thread(a_th), .alloc_txn(a_tx),
    .alloc_data(a_data),
    .fill_valid(fill_valid), .fill_id(pre_id), .fill_thread(pre_thread),
    .fill_txn(pre_txn), .fill_data(pre_data),
    .lk_valid(wr_valid), .lk_line(wr_addr[ADDR_W-1:OFF_W]), .lk_data(wr_data),
    .lk_match(lk_match), .lk_hit(lk_hit), .lk_result(lk_result)
  );

  // two-stage response pipeline
  logic          s1_valid, s1_hit;
  logic [DW-1:0] s1_result;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid     <= 1'b0;
      s1_hit       <= 1'b0;
      s1_result    <= '0;
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_result   <= '0;
      rsp_fallback <= 1'b0;
    end else begin
      s1_valid     <= wr_valid;
      s1_hit       <= lk_hit;
      s1_result    <= lk_result;
      rsp_valid    <= s1_valid;
      rsp_hit      <= s1_valid && s1_hit;
      rsp_result   <= s1_valid ? s1_result : '0;
      rsp_fallback <= s1_valid && !s1_hit;
    end
  end
endmodule

// File: rtl/prb_checker.sv
module prb_checker #(
  parameter int ENTRIES = 8,
  parameter int SZ_W    = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pre_valid,
  input logic               pre_ready,
  input logic [1:0]         pre_kind,
  input logic [SZ_W-1:0]    pre_size,
  input logic               wr_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_fallback,
  input logic [ENTRIES-1:0] lk_match
);
  AST_RSP_TWO_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> ##1 rsp_valid); // R5
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> ##1 !rsp_valid); // R5
  AST_HIT_OR_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_fallback)); // R6
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_fallback)); // R6
  AST_ONE_COPY_PER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R12
  AST_SPLIT_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_valid && pre_ready && pre_kind[0] && pre_size != '0) |=> !pre_ready); // R2
endmodule

bind prexec_result_buf prb_checker #(.ENTRIES(ENTRIES), .SZ_W(SZ_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .pre_valid(pre_valid), .pre_ready(pre_ready),
  .pre_kind(pre_kind), .pre_size(pre_size), .wr_valid(wr_valid),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fallback(rsp_fallback),
  .lk_match(lk_match)
);

// File: tb/prexec_result_buf_test.sv
module prexec_result_buf_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pre_valid, pre_ready;
  logic [1:0]  pre_kind;
  logic [3:0]  pre_id;
  logic [2:0]  pre_thread;
  logic [7:0]  pre_txn;
  logic [31:0] pre_addr;
  logic [15:0] pre_size;
  logic [31:0] pre_data;
  logic        wr_valid;
  logic [31:0] wr_addr, wr_data;
  logic        rsp_valid, rsp_hit, rsp_fallback;
  logic [31:0] rsp_result;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  prexec_result_buf uut (
    .clk(clk), .rst_n(rst_n), .pre_valid(pre_valid), .pre_ready(pre_ready),
    .pre_kind(pre_kind), .pre_id(pre_id), .pre_thread(pre_thread),
    .pre_txn(pre_txn), .pre_addr(pre_addr), .pre_size(pre_size),
    .pre_data(pre_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_result(rsp_result), .rsp_fallback(rsp_fallback)
  );

  function automatic logic [31:0] model_res(input logic [31:0] d, input logic [31:0] a);
    return (d ^ (a >> 6)) + 32'h3C6E_F372;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] k, input logic [3:0] id, input logic [2:0] th,
                        input logic [7:0] tx, input logic [31:0] a, input logic [15:0] s,
                        input logic [31:0] d, output int busy_cycles);
    @(negedge clk);
    pre_valid = 1'b1; pre_kind = k; pre_id = id; pre_thread = th;
    pre_txn = tx; pre_addr = a; pre_size = s; pre_data = d;
    @(negedge clk);
    pre_valid = 1'b0;
    busy_cycles = 0;
    while (!pre_ready) begin
      busy_cycles++;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input bit exp_hit,
                          input logic [31:0] exp_res, input string req);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    check(req, "rsp_valid in between", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    check(req, "rsp_valid", 32'(rsp_valid), 32'd1);
    check(req, "rsp_hit", 32'(rsp_hit), 32'(exp_hit));
    check(req, "rsp_fallback", 32'(rsp_fallback), 32'(!exp_hit));
    check(req, "rsp_result", rsp_result, exp_hit ? exp_res : 32'd0);
  endtask

  task automatic t_reset;
    check("R1", "pre_ready", 32'(pre_ready), 32'd1);
    check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1", "rsp_hit", 32'(rsp_hit), 32'd0);
    check("R1", "rsp_fallback", 32'(rsp_fallback), 32'd0);
    do_write(32'h0000_1000, 32'h1, 1'b0, 0, "R1");
  endtask

  task automatic t_hit_consume;
    int b;
    do_req(2'b11, 4'd1, 3'd1, 8'd1, 32'h0000_2040, 16'd8, 32'hCAFE_0001, b);
    do_write(32'h0000_2040, 32'hCAFE_0001, 1'b1, model_res(32'hCAFE_0001, 32'h2040), "R4");
    do_write(32'h0000_2040, 32'hCAFE_0001, 1'b0, 0, "R8");
    do_write(32'h0000_2080, 32'h5, 1'b0, 0, "R6");
  endtask

  task automatic t_mismatch;
    int b;
    do_req(2'b11, 4'd2, 3'd0, 8'd2, 32'h0000_4000, 16'd4, 32'h1111_2222, b);
    do_write(32'h0000_4000, 32'h1111_2223, 1'b0, 0, "R7");
    do_write(32'h0000_4000, 32'h1111_2222, 1'b0, 0, "R7");
  endtask

  task automatic t_pending;
    int b;
    do_req(2'b01, 4'd7, 3'd2, 8'd9, 32'h0000_5000, 16'd4, 32'h0, b);
    do_write(32'h0000_5000, 32'hABCD, 1'b0, 0, "R9");
    do_req(2'b10, 4'd7, 3'd2, 8'd9, 32'h0, 16'd0, 32'hABCD, b);
    do_write(32'h0000_5000, 32'hABCD, 1'b0, 0, "R9");
    do_req(2'b01, 4'd5, 3'd3, 8'd4, 32'h0000_6000, 16'd4, 32'h0, b);
    do_req(2'b10, 4'd6, 3'd3, 8'd4, 32'h0, 16'd0, 32'hBAD0_BAD0, b);
    do_req(2'b10, 4'd5, 3'd1, 8'd4, 32'h0, 16'd0, 32'hBAD1_BAD1, b);
    do_req(2'b10, 4'd5, 3'd3, 8'd5, 32'h0, 16'd0, 32'hBAD2_BAD2, b);
    do_req(2'b10, 4'd5, 3'd3, 8'd4, 32'h0, 16'd0, 32'h0600_D000, b);
    do_write(32'h0000_6000, 32'h0600_D000, 1'b1, model_res(32'h0600_D000, 32'h6000), "R9");
  endtask

  task automatic t_duplicate;
    int b;
    do_req(2'b11, 4'd3, 3'd0, 8'd0, 32'h0000_7000, 16'd16, 32'hD1D1_D1D1, b);
    do_req(2'b11, 4'd4, 3'd0, 8'd0, 32'h0000_7010, 16'd16, 32'hD2D2_D2D2, b);
    do_write(32'h0000_7000, 32'hD2D2_D2D2, 1'b1, model_res(32'hD2D2_D2D2, 32'h7000), "R12");
    do_write(32'h0000_7000, 32'hD2D2_D2D2, 1'b0, 0, "R12");
    do_write(32'h0000_7000, 32'hD1D1_D1D1, 1'b0, 0, "R12");
  endtask

  task automatic t_split;
    int b;
    do_req(2'b11, 4'd8, 3'd0, 8'd0, 32'h0000_3030, 16'h0060, 32'h7777_0000, b);
    check("R2", "busy cycles for 3 lines", 32'(b), 32'd3);
    do_write(32'h0000_3080, 32'h7777_0000, 1'b1, model_res(32'h7777_0000, 32'h3080), "R2");
    do_write(32'h0000_3000, 32'h7777_0000, 1'b1, model_res(32'h7777_0000, 32'h3000), "R2");
    do_write(32'h0000_3040, 32'h7777_0000, 1'b1, model_res(32'h7777_0000, 32'h3040), "R2");
    do_write(32'h0000_30C0, 32'h7777_0000, 1'b0, 0, "R2");
    do_req(2'b11, 4'd8, 3'd0, 8'd0, 32'h0000_8000, 16'd0, 32'h9, b);
    check("R2", "busy cycles for size 0", 32'(b), 32'd0);
    do_write(32'h0000_8000, 32'h9, 1'b0, 0, "R2");
  endtask

  task automatic t_kind_none;
    int b;
    do_req(2'b00, 4'd9, 3'd0, 8'd0, 32'h0000_9000, 16'd64, 32'h42, b);
    check("R3", "busy cycles for kind 00", 32'(b), 32'd0);
    do_write(32'h0000_9000, 32'h42, 1'b0, 0, "R3");
  endtask

  task automatic t_timeout;
    int b;
    do_req(2'b11, 4'd10, 3'd0, 8'd0, 32'h0000_A000, 16'd4, 32'h7100, b);
    repeat (300) @(negedge clk);
    do_write(32'h0000_A000, 32'h7100, 1'b1, model_res(32'h7100, 32'hA000), "R10");
    do_req(2'b11, 4'd10, 3'd0, 8'd0, 32'h0000_A000, 16'd4, 32'h7200, b);
    repeat (2100) @(negedge clk);
    do_write(32'h0000_A000, 32'h7200, 1'b0, 0, "R10");
  endtask

  task automatic t_full;
    int b;
    do_req(2'b11, 4'd11, 3'd0, 8'd0, 32'h0000_1000, 16'd512, 32'hF00D_0000, b);
    check("R11", "busy cycles for 8 lines", 32'(b), 32'd8);
    do_req(2'b11, 4'd12, 3'd0, 8'd0, 32'h0000_2000, 16'd4, 32'hF00D_0001, b);
    do_write(32'h0000_1000, 32'hF00D_0000, 1'b0, 0, "R11");
    for (int i = 1; i < 8; i++) begin
      logic [31:0] a;
      a = 32'h0000_1000 + 32'(i * 64);
      do_write(a, 32'hF00D_0000, 1'b1, model_res(32'hF00D_0000, a), "R11");
    end
    do_write(32'h0000_2000, 32'hF00D_0001, 1'b1, model_res(32'hF00D_0001, 32'h2000), "R11");
  endtask

  initial begin
    rst_n = 1'b0;
    pre_valid = 1'b0; pre_kind = 2'b00; pre_id = '0; pre_thread = '0;
    pre_txn = '0; pre_addr = '0; pre_size = '0; pre_data = '0;
    wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hit_consume();
    t_mismatch();
    t_pending();
    t_duplicate();
    t_split();
    t_kind_none();
    t_timeout();
    t_full();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule